// File: doc/BRIEF.md
# Shared Multi-Processor Configuration Register Block

This block is a memory-mapped register file shared by several virtual processors (VPs) of one cluster. Every bus access carries the index of the VP that issues it. The address space has three regions: a global region of cluster-wide registers, a local window, and a redirected window. The local window always reaches the requester's own per-VP registers. The redirected window reaches the registers of whichever VP the requester has chosen through its own target selector.

Each VP owns two registers: a target selector and a boot-vector register. The boot-vector register drives that VP's exception base output, sign-extended to 64 bits. The global region has three writable registers:

- the block's own relocation base, which is broadcast to every VP shifted right by 4;
- two peripheral window registers, each supplying the base address and enable of a downstream address window.

Each peripheral window register accepts writes only while a strap input reports that its peripheral is fitted.

The bus has no back-pressure, so every request is taken in the cycle in which `req_valid` is high. A read returns its data on `rsp_rdata` with `rsp_valid` high in the following cycle. A write produces no response.

Top module: `mpcfg_regs`

## Requirements
- R1: After reset every target selector is 0 and every boot-vector register holds 0xBFC00000. Every `exc_base` therefore reads 0xFFFFFFFFBFC00000. Both peripheral windows read base 0 with their enable low, and `self_base_shr` equals `SELF_RST` >> 4.
- R2: Accesses at the local window (0x2000 + offset) use the requesting VP's own registers. The offsets are 0x10 for the VP count, 0x18 for the selector and 0x20 for the boot vector.
- R3: Accesses at the redirected window (0x4000 + the same offsets) read and write the registers of the VP named by the requester's selector. This includes that VP's own selector.
- R4: A selector write, through either window, stores `wdata[7:0]` only when that value is below `NUM_VP`. Any other value leaves the selector unchanged.
- R5: Reading offset 0x10 in either window returns `NUM_VP` - 1.
- R6: A boot-vector write keeps bits 31:12 and clears the rest. The target VP's `exc_base` shows the stored value, sign-extended from bit 31, in the cycle after the write.
- R7: Writes to peripheral window registers at 0x080 (window 0) and 0x088 (window 1) keep bits 31:17 and bit 0. Bits 31:17 drive `winN_base`, with its low bits zero, and bit 0 drives `winN_en`. The stored value reads back.
- R8: A write to a peripheral window register is ignored while its `present` bit is low. The status registers at 0x0D0 (window 0) and 0x0F0 (window 1) read 1 or 0 to match the strap.
- R9: The constant registers read as follows: 0x000 reads 0, 0x030 reads `REVISION`, and 0x040 reads 0x00100000 (bypass bit 20 only).
- R10: Reads of unmapped offsets return 0, and writes to unmapped offsets change no register or output.
- R11: A write to 0x008 keeps bits 31:15. The value reads back, and `self_base_shr` equals the stored value shifted right by 4.
- R12: `rsp_valid` is high exactly in the cycle after an accepted read, never after a write or an idle cycle.
- R13: A window access from a requester index of `NUM_VP` or higher reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset into the block |
| req_wdata | input | 32 | Write data |
| req_vp | input | VP_IDW | Index of the requesting VP |
| present | input | 2 | Peripheral fitted straps, bit N for window N |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| win0_base | output | 32 | Peripheral window 0 base address |
| win0_en | output | 1 | Peripheral window 0 enable |
| win1_base | output | 32 | Peripheral window 1 base address |
| win1_en | output | 1 | Peripheral window 1 enable |
| self_base_shr | output | 32 | Block base shifted right by 4, broadcast to all VPs |
| exc_base | output | NUM_VP x 64 | Per-VP sign-extended exception base |

## Verification
Random traffic from three VPs plus one out-of-range index is mixed over local, redirected, global and unmapped addresses. This mix separates a design that resolves the redirected target from the wrong VP from one that resolves it correctly. Selector data is drawn from a small range that straddles `NUM_VP`, so accepted and dropped selector writes both occur often. The peripheral straps toggle during the run, which separates a design that gates window writes from one that does not. Directed cases then cover a chained redirection, a boot-vector write through the redirected window, and the reset image.

// File: rtl/mpcfg_pkg.sv
package mpcfg_pkg;

  typedef enum logic [1:0] {
    SP_GLOBAL,
    SP_LOCAL,
    SP_OTHER,
    SP_NONE
  } space_e;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_CFG,
    RG_SELF,
    RG_REV,
    RG_L2,
    RG_WB0,
    RG_WB1,
    RG_WS0,
    RG_WS1,
    RG_VCFG,
    RG_VSEL,
    RG_VRB
  } reg_e;

  typedef struct packed {
    space_e space;
    reg_e   rg;
  } dec_t;

  localparam logic [31:0] RB_MSK   = 32'hFFFF_F000;
  localparam logic [31:0] RB_RST   = 32'hBFC0_0000;
  localparam logic [31:0] WIN_MSK  = 32'hFFFE_0001;
  localparam logic [31:0] WADR_MSK = 32'hFFFE_0000;
  localparam logic [31:0] SELF_MSK = 32'hFFFF_8000;
  localparam logic [31:0] L2_VAL   = 32'h0010_0000;

endpackage

// File: rtl/mpcfg_decode.sv
module mpcfg_decode
  import mpcfg_pkg::*;
(
  input  logic [15:0] addr,
  output dec_t        dec
);
  logic [12:0] off;
  assign off = addr[12:0];

  always_comb begin
    dec.space = SP_NONE;
    dec.rg    = RG_NONE;
    unique case (addr[15:13])
      3'd0: begin
        if (off[12:8] == 5'd0) begin
          dec.space = SP_GLOBAL;
          case (off[7:0])
            8'h00:   dec.rg = RG_CFG;
            8'h08:   dec.rg = RG_SELF;
            8'h30:   dec.rg = RG_REV;
            8'h40:   dec.rg = RG_L2;
            8'h80:   dec.rg = RG_WB0;
            8'h88:   dec.rg = RG_WB1;
            8'hD0:   dec.rg = RG_WS0;
            8'hF0:   dec.rg = RG_WS1;
            default: dec.rg = RG_NONE;
          endcase
        end
      end
      3'd1, 3'd2: begin
        dec.space = (addr[15:13] == 3'd1) ? SP_LOCAL : SP_OTHER;
        case (off)
          13'h010: dec.rg = RG_VCFG;
          13'h018: dec.rg = RG_VSEL;
          13'h020: dec.rg = RG_VRB;
          default: dec.rg = RG_NONE;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mpcfg_vp_bank.sv
module mpcfg_vp_bank
  import mpcfg_pkg::*;
#(
  parameter int NUM_VP = 1,
  parameter int VP_IDW = 1,
  parameter int SEL_W  = 8,
  parameter int XW     = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  dec_t                       dec,
  input  logic [VP_IDW-1:0]          req_vp,
  input  logic [31:0]                wdata,
  output logic [31:0]                rd_data,
  output logic [NUM_VP-1:0][XW-1:0]  exc_base
);
  logic [VP_IDW-1:0] sel_q [NUM_VP];
  logic [31:0]       rb_q  [NUM_VP];

  logic              req_ok;
  logic              in_win;
  logic              sel_ok;
  logic [VP_IDW-1:0] req_idx;
  logic [VP_IDW-1:0] tgt;
  logic              wr_en;

  assign req_ok  = 32'(req_vp) < 32'(NUM_VP);
  assign req_idx = req_ok ? req_vp : '0;
  assign in_win  = req_ok && (dec.space == SP_LOCAL || dec.space == SP_OTHER);
  assign tgt     = (dec.space == SP_OTHER) ? sel_q[req_idx] : req_idx;
  assign sel_ok  = 32'(wdata[SEL_W-1:0]) < 32'(NUM_VP);
  assign wr_en   = acc_valid && acc_write && in_win;

  for (genvar g = 0; g < NUM_VP; g++) begin : g_vp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q[g] <= '0;
        rb_q[g]  <= RB_RST & RB_MSK;
      end else if (wr_en && tgt == VP_IDW'(g)) begin
        if (dec.rg == RG_VSEL && sel_ok) sel_q[g] <= wdata[VP_IDW-1:0];
        if (dec.rg == RG_VRB)            rb_q[g]  <= wdata & RB_MSK;
      end
    end

    assign exc_base[g] = {{(XW-32){rb_q[g][31]}}, rb_q[g]};

    // R4
    sel_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sel_q[g]) < 32'(NUM_VP));

    // R4
    bad_sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dec.rg == RG_VSEL && !sel_ok) |=> $stable(sel_q[g]));

    // R6
    exc_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_base[g][XW-1:32] == {(XW-32){exc_base[g][31]}});
  end

  always_comb begin
    rd_data = '0;
    if (in_win) begin
      case (dec.rg)
        RG_VCFG: rd_data = 32'(NUM_VP - 1);
        RG_VSEL: rd_data = 32'(sel_q[tgt]);
        RG_VRB:  rd_data = rb_q[tgt];
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/mpcfg_win_reg.sv
module mpcfg_win_reg
  import mpcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        present,
  input  logic [31:0] wdata,
  output logic [31:0] q,
  output logic [31:0] base,
  output logic        en
);
  always_ff @(posedge clk) begin
    if (!rst_n)            q <= '0;
    else if (we && present) q <= wdata & WIN_MSK;
  end

  assign base = q & WADR_MSK;
  assign en   = q[0];

  // R8
  absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !present |=> $stable(q));
endmodule

// File: rtl/mpcfg_regs.sv
module mpcfg_regs
  import mpcfg_pkg::*;
#(
  parameter int          NUM_VP   = 1,
  parameter int          VP_IDW   = (NUM_VP > 1) ? $clog2(NUM_VP) : 1,
  parameter int          SEL_W    = 8,
  parameter int          XW       = 64,
  parameter logic [31:0] REVISION = 32'h0000_0800,
  parameter logic [31:0] SELF_RST = 32'h1FBF_8000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [15:0]               req_addr,
  input  logic [31:0]               req_wdata,
  input  logic [VP_IDW-1:0]         req_vp,
  input  logic [1:0]                present,
  output logic                      rsp_valid,
  output logic [31:0]               rsp_rdata,
  output logic [31:0]               win0_base,
  output logic                      win0_en,
  output logic [31:0]               win1_base,
  output logic                      win1_en,
  output logic [31:0]               self_base_shr,
  output logic [NUM_VP-1:0][XW-1:0] exc_base
);
  localparam int NWIN = 2;

  dec_t        dec;
  logic [31:0] bank_rd;
  logic [31:0] self_q;
  logic [31:0] glob_rd;
  logic        wr;
  logic [31:0] win_q    [NWIN];
  logic [31:0] win_base [NWIN];
  logic        win_en   [NWIN];

  assign wr = req_valid && req_write;

  mpcfg_decode u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  mpcfg_vp_bank #(
    .NUM_VP (NUM_VP),
    .VP_IDW (VP_IDW),
    .SEL_W  (SEL_W),
    .XW     (XW)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (req_valid),
    .acc_write (req_write),
    .dec       (dec),
    .req_vp    (req_vp),
    .wdata     (req_wdata),
    .rd_data   (bank_rd),
    .exc_base  (exc_base)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam reg_e MYREG = (w == 0) ? RG_WB0 : RG_WB1;
    mpcfg_win_reg u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr && dec.rg == MYREG),
      .present (present[w]),
      .wdata   (req_wdata),
      .q       (win_q[w]),
      .base    (win_base[w]),
      .en      (win_en[w])
    );
  end

  assign win0_base = win_base[0];
  assign win0_en   = win_en[0];
  assign win1_base = win_base[1];
  assign win1_en   = win_en[1];

  always_ff @(posedge clk) begin
    if (!rst_n)                    self_q <= SELF_RST & SELF_MSK;
    else if (wr && dec.rg == RG_SELF) self_q <= req_wdata & SELF_MSK;
  end
  assign self_base_shr = self_q >> 4;

  always_comb begin
    case (dec.rg)
      RG_SELF: glob_rd = self_q;
      RG_REV:  glob_rd = REVISION;
      RG_L2:   glob_rd = L2_VAL;
      RG_WB0:  glob_rd = win_q[0];
      RG_WB1:  glob_rd = win_q[1];
      RG_WS0:  glob_rd = 32'(present[0]);
      RG_WS1:  glob_rd = 32'(present[1]);
      default: glob_rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? (glob_rd | bank_rd) : '0;
    end
  end

  // R12
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R12
  no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R11
  self_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(self_base_shr));
endmodule

// File: tb/mpcfg_regs_test.sv
module mpcfg_regs_test;
  localparam int NVP = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_vp = '0;
  logic [1:0]  present = 2'b11;
  logic rsp_valid;
  logic [31:0] rsp_rdata, win0_base, win1_base, self_base_shr;
  logic win0_en, win1_en;
  logic [NVP-1:0][63:0] exc_base;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_sel [NVP];
  logic [31:0] m_rb  [NVP];
  logic [31:0] m_win [2];
  logic [31:0] m_self;

  mpcfg_regs #(.NUM_VP(NVP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_vp(req_vp),
    .present(present), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .win0_base(win0_base), .win0_en(win0_en), .win1_base(win1_base),
    .win1_en(win1_en), .self_base_shr(self_base_shr), .exc_base(exc_base)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] a, input int vp);
    if (a[15:13] != 0 && vp >= NVP) return "R13";
    case (a)
      16'h0000, 16'h0030, 16'h0040: return "R9";
      16'h0008: return "R11";
      16'h0080, 16'h0088: return "R7";
      16'h00D0, 16'h00F0: return "R8";
      16'h2010, 16'h4010: return "R5";
      16'h2018, 16'h2020: return "R2";
      16'h4018, 16'h4020: return "R3";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input int vp, input logic [15:0] a);
    int t;
    case (a)
      16'h0008: return m_self;
      16'h0030: return 32'h800;
      16'h0040: return 32'h0010_0000;
      16'h0080: return m_win[0];
      16'h0088: return m_win[1];
      16'h00D0: return 32'(present[0]);
      16'h00F0: return 32'(present[1]);
      default: ;
    endcase
    if (vp >= NVP) return 0;
    if (a[15:13] == 3'd1) t = vp;
    else if (a[15:13] == 3'd2) t = int'(m_sel[vp]);
    else return 0;
    case (a[12:0])
      13'h010: return NVP - 1;
      13'h018: return m_sel[t];
      13'h020: return m_rb[t];
      default: return 0;
    endcase
  endfunction

  task automatic model_write(input int vp, input logic [15:0] a, input logic [31:0] d);
    int t;
    case (a)
      16'h0008: m_self = d & 32'hFFFF_8000;
      16'h0080: if (present[0]) m_win[0] = d & 32'hFFFE_0001;
      16'h0088: if (present[1]) m_win[1] = d & 32'hFFFE_0001;
      default: ;
    endcase
    if (vp < NVP && (a[15:13] == 3'd1 || a[15:13] == 3'd2)) begin
      t = (a[15:13] == 3'd1) ? vp : int'(m_sel[vp]);
      if (a[12:0] == 13'h018 && d[7:0] < NVP) m_sel[t] = 32'(d[7:0]);
      if (a[12:0] == 13'h020) m_rb[t] = d & 32'hFFFF_F000;
    end
  endtask

  task automatic check_outputs(input string tag);
    for (int i = 0; i < NVP; i++)
      check(exc_base[i] == {{32{m_rb[i][31]}}, m_rb[i]}, {tag, " exc_base R6"},
            exc_base[i], {{32{m_rb[i][31]}}, m_rb[i]});
    check(win0_base == (m_win[0] & 32'hFFFE_0000) && win0_en == m_win[0][0],
          {tag, " win0 R7"}, {win0_base, 31'd0, win0_en}, {m_win[0] & 32'hFFFE_0000, 31'd0, m_win[0][0]});
    check(win1_base == (m_win[1] & 32'hFFFE_0000) && win1_en == m_win[1][0],
          {tag, " win1 R7"}, {win1_base, 31'd0, win1_en}, {m_win[1] & 32'hFFFE_0000, 31'd0, m_win[1][0]});
    check(self_base_shr == (m_self >> 4), {tag, " self R11"}, self_base_shr, m_self >> 4);
  endtask

  task automatic op(input bit w, input int vp, input logic [15:0] a, input logic [31:0] d);
    logic [31:0] e;
    string tg;
    e  = exp_read(vp, a);
    tg = tag_of(a, vp);
    @(negedge clk);
    req_valid = 1; req_write = w; req_vp = 2'(vp); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (w) begin
      check(rsp_valid == 0, "R12 no response after write", 64'(rsp_valid), 0);
      model_write(vp, a, d);
      check_outputs(tg);
    end else begin
      check(rsp_valid == 1 && rsp_rdata == e, {tg, " read data R12"},
            {31'd0, rsp_valid, rsp_rdata}, {32'd1, e});
    end
  endtask

  logic [15:0] alist [16] = '{16'h0000, 16'h0008, 16'h0030, 16'h0040, 16'h0080,
    16'h0088, 16'h00D0, 16'h00F0, 16'h2010, 16'h2018, 16'h2020, 16'h4010,
    16'h4018, 16'h4020, 16'h2028, 16'h0108};

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < NVP; i++) begin m_sel[i] = 0; m_rb[i] = 32'hBFC0_0000; end
    m_win[0] = 0; m_win[1] = 0; m_self = 32'h1FBF_8000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset image
    check(rsp_valid == 0, "R1 rsp_valid at reset", 64'(rsp_valid), 0);
    for (int i = 0; i < NVP; i++)
      check(exc_base[i] == 64'hFFFF_FFFF_BFC0_0000, "R1 exc_base reset",
            exc_base[i], 64'hFFFF_FFFF_BFC0_0000);
    check(!win0_en && !win1_en && win0_base == 0 && win1_base == 0, "R1 windows off",
          {win0_base, 31'd0, win0_en}, 0);
    check(self_base_shr == 32'h01FB_F800, "R1 self base", self_base_shr, 32'h01FB_F800);
    op(0, 1, 16'h2018, 0);  // R1 selector 0

    // R4 invalid selector dropped, valid accepted
    op(1, 0, 16'h2018, 32'hFFFF_FF05);
    op(0, 0, 16'h2018, 0);
    op(1, 0, 16'h2018, 32'hABCD_0002);
    op(0, 0, 16'h2018, 0);
    // R3 boot-vector through redirected window reaches VP2
    op(1, 0, 16'h4020, 32'h1234_5678);
    op(0, 2, 16'h2020, 0);
    // R3 redirected selector write changes VP2's selector; chain read
    op(1, 0, 16'h4018, 32'h1);
    op(0, 2, 16'h2018, 0);
    op(0, 0, 16'h4018, 0);
    // R6 positive value sign extension
    op(1, 1, 16'h2020, 32'h7FFF_FFFF);
    // R8 absent peripheral ignores writes
    present = 2'b10;
    op(1, 0, 16'h0080, 32'hFFFF_FFFF);
    op(0, 0, 16'h00D0, 0);
    op(1, 0, 16'h0088, 32'hFFFF_FFFF);
    present = 2'b11;
    // R13 out-of-range requester
    op(0, 3, 16'h2010, 0);
    op(1, 3, 16'h2020, 32'h0);
    // R10 unmapped
    op(1, 1, 16'h0108, 32'hFFFF_FFFF);
    op(0, 1, 16'h0010, 0);

    for (int n = 0; n < 800; n++) begin
      int vp;
      logic [15:0] a;
      logic [31:0] d;
      if (n % 100 == 0) present = 2'($urandom_range(0, 3));
      vp = $urandom_range(0, 3);
      a  = alist[$urandom_range(0, 15)];
      d  = $urandom;
      if (a[12:0] == 13'h018) d[7:0] = 8'($urandom_range(0, 5));
      op($urandom_range(0, 1) == 1, vp, a, d);
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check(rsp_valid == 0, "R12 idle no response", 64'(rsp_valid), 0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule